// File: doc/BRIEF.md
# Closest-Rate Parent and Divisor Search Engine

This block takes a requested output rate and finds the achievable rate nearest to it. Each achievable rate is one parent rate divided by one divider setting. Parent rates come in on a flat port that holds one word per parent. Divider codes are turned into divisors by one of four decoding modes, chosen by a parameter. The engine visits candidates one at a time and divides each one with a shared multi-cycle restoring divider. It keeps the best candidate found so far and stops early when it reaches an exact match.

A second mode, chosen per search, uses a small preset list instead of the full sweep. Each preset entry names a parent and a target rate. An entry counts only when its parent rate is an exact multiple of its target. A one-cycle start pulse begins a search. A one-cycle done pulse reports the chosen parent index, that parent's rate and the achieved rate. When no candidate qualifies, the done pulse comes with an error flag.

Top module: `rs_search`

## Requirements
- R1: After reset, done_o and err_o are low and par_idx_o, par_rate_o and rate_o are zero.
- R2: Without presets, the search visits parents in ascending index order and, for each parent, divider codes from 0 upward. Each candidate rate is the integer quotient of the parent rate and the decoded divisor. The reported result is the candidate with the smallest absolute difference to the requested rate.
- R3: The number of codes visited per parent depends on the mode, where m = 2^DIV_W - 1. Plain mode (mode 0) visits m+1 codes. One-based mode (mode 1) visits m codes. Power-of-two mode (mode 2) visits 2^m codes. Table mode (mode 3) visits as many codes as the largest table divisor, which is 2^DIV_W.
- R4: Code c decodes as follows. Plain: c+1. One-based: c. Power-of-two: 2^c. Table: 2*(c+1) when c < 2^(DIV_W-1), otherwise 0. A decoded divisor of 0 is skipped and never divided by.
- R5: A later candidate replaces the held one only when its difference is strictly smaller, so on a tie the earlier one in the visiting order is kept.
- R6: A candidate with zero difference ends the search at once. An exact match on the first candidate completes within 40 cycles of start.
- R7: With preset_en_i high at start, each entry (parent index, target rate) is valid only when the target is nonzero and the parent rate modulo the target is zero. A valid entry offers the target rate as its candidate. Invalid entries are skipped. The same tie and early-exit rules apply.
- R8: When no candidate qualifies, done_o comes with err_o high and par_idx_o, par_rate_o and rate_o are all zero.
- R9: done_o is high for exactly one cycle per accepted start. The outputs hold their values until the next completion.
- R10: A start pulse during a running search is ignored. The requested rate and the mode are captured at the accepted start, so later changes on req_rate_i or preset_en_i do not affect the result.
- R11: In power-of-two mode, a code c >= RATE_W yields candidate rate 0, because the quotient is zero. A parent rate of 0 yields candidate rate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| preset_en_i | input | 1 | Use the preset list for this search |
| req_rate_i | input | RATE_W | Requested rate |
| parent_rates_i | input | NUM_PARENTS*RATE_W | Parent rates, parent k at bits k*RATE_W upward |
| preset_par_i | input | NUM_PRESETS*PIDX_W | Parent index of each preset entry |
| preset_rate_i | input | NUM_PRESETS*RATE_W | Target rate of each preset entry |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No candidate found, valid with done_o |
| par_idx_o | output | PIDX_W | Chosen parent index |
| par_rate_o | output | RATE_W | Rate of the chosen parent |
| rate_o | output | RATE_W | Achieved rate |

## Verification
A wrong code counter or a wrong decoded divisor appears at the next done pulse as a different parent or a different rate_o. The bench catches this by running all four divider modes side by side against an arithmetic model. A best-candidate tracker that uses a non-strict comparison shows up on tie inputs as a later parent or a smaller rate. A broken early exit shows up only as extra latency, so the latency of an exact first-candidate match is measured against a fixed bound. A search that stays busy and ignores a second start pulse must still produce exactly one done pulse, carrying the first request's result.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {DM_PLAIN, DM_ONE, DM_POW2, DM_TABLE} div_mode_e;

  // codes scanned per parent
  function automatic int code_count(div_mode_e m, int dw);
    int mask;
    mask = (1 << dw) - 1;
    case (m)
      DM_ONE:   return mask;
      DM_POW2:  return 1 << mask;
      DM_TABLE: return 2 * (1 << (dw - 1));
      default:  return mask + 1;
    endcase
  endfunction

  // divisor for a code, 0 means unusable
  function automatic int decode_div(div_mode_e m, int dw, int code);
    case (m)
      DM_ONE:   return code;
      DM_POW2:  return (code < 31) ? (1 << code) : 0;
      DM_TABLE: return (code < (1 << (dw - 1))) ? 2 * (code + 1) : 0;
      default:  return code + 1;
    endcase
  endfunction
endpackage

// File: rtl/rs_divider.sv
module rs_divider #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0]     quo_q, rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [W:0]       trial;

  assign trial = {rem_q, quo_q[W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      quo_q  <= num_i;
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= CNT_W'(W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (trial >= {1'b0, den_q}) begin
        rem_q <= W'(trial - {1'b0, den_q});
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // R2
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rem_q < den_q));
endmodule

// File: rtl/rs_best.sv
module rs_best #(
  parameter int RATE_W = 16,
  parameter int PIDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [PIDX_W-1:0] par_i,
  input  logic [RATE_W-1:0] prate_i,
  input  logic [RATE_W-1:0] req_i,
  output logic              have_o,
  output logic              exact_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [PIDX_W-1:0] par_o,
  output logic [RATE_W-1:0] prate_o
);
  logic              have_q;
  logic [RATE_W-1:0] gap_q, rate_q, prate_q, gap;
  logic [PIDX_W-1:0] par_q;
  logic              take;

  assign gap  = (rate_i >= req_i) ? (rate_i - req_i) : (req_i - rate_i);
  // strict compare keeps the earlier candidate on a tie
  assign take = vld_i && (!have_q || (gap < gap_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      gap_q   <= '0;
      rate_q  <= '0;
      prate_q <= '0;
      par_q   <= '0;
    end else if (clr_i) begin
      have_q  <= 1'b0;
      gap_q   <= '0;
    end else if (take) begin
      have_q  <= 1'b1;
      gap_q   <= gap;
      rate_q  <= rate_i;
      prate_q <= prate_i;
      par_q   <= par_i;
    end
  end

  assign have_o  = have_q;
  assign exact_o = have_q && (gap_q == '0);
  assign rate_o  = rate_q;
  assign prate_o = prate_q;
  assign par_o   = par_q;

  // R5
  gap_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && !clr_i) |=> (gap_q <= $past(gap_q)));
endmodule

// File: rtl/rs_search.sv
module rs_search import rs_pkg::*; #(
  parameter int        NUM_PARENTS = 4,
  parameter int        NUM_PRESETS = 4,
  parameter int        RATE_W      = 16,
  parameter int        DIV_W       = 3,
  parameter div_mode_e DIV_MODE    = DM_PLAIN,
  localparam int       PIDX_W      = (NUM_PARENTS > 1) ? $clog2(NUM_PARENTS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          preset_en_i,
  input  logic [RATE_W-1:0]             req_rate_i,
  input  logic [NUM_PARENTS*RATE_W-1:0] parent_rates_i,
  input  logic [NUM_PRESETS*PIDX_W-1:0] preset_par_i,
  input  logic [NUM_PRESETS*RATE_W-1:0] preset_rate_i,
  output logic                          done_o,
  output logic                          err_o,
  output logic [PIDX_W-1:0]             par_idx_o,
  output logic [RATE_W-1:0]             par_rate_o,
  output logic [RATE_W-1:0]             rate_o
);
  localparam int MAX_IDX = (NUM_PARENTS > NUM_PRESETS) ? NUM_PARENTS : NUM_PRESETS;
  localparam int IDX_W   = $clog2(MAX_IDX + 1);
  localparam int CODES   = code_count(DIV_MODE, DIV_W);
  localparam int CODE_W  = (1 << DIV_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_DIV, S_CHK, S_FIN} st_e;

  st_e               st_q;
  logic              preset_q, done_q, err_q;
  logic [RATE_W-1:0] req_q, tgt_q, cand_prate_q;
  logic [PIDX_W-1:0] cand_par_q, par_q;
  logic [RATE_W-1:0] prate_q, rate_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] code_q;

  logic [RATE_W-1:0] prate_a [NUM_PARENTS];
  logic [PIDX_W-1:0] ppar_a  [NUM_PRESETS];
  logic [RATE_W-1:0] ptgt_a  [NUM_PRESETS];

  for (genvar k = 0; k < NUM_PARENTS; k++) begin : g_par
    assign prate_a[k] = parent_rates_i[k*RATE_W +: RATE_W];
  end
  for (genvar e = 0; e < NUM_PRESETS; e++) begin : g_pre
    assign ppar_a[e] = preset_par_i[e*PIDX_W +: PIDX_W];
    assign ptgt_a[e] = preset_rate_i[e*RATE_W +: RATE_W];
  end

  logic [RATE_W-1:0] scan_prate, ent_tgt, ent_prate;
  logic [PIDX_W-1:0] ent_par;
  logic              scan_end, pre_end, over, par_ok, last_code;
  int                div_int;

  always_comb begin
    scan_prate = '0;
    ent_par    = '0;
    ent_tgt    = '0;
    ent_prate  = '0;
    for (int k = 0; k < NUM_PARENTS; k++)
      if (idx_q == IDX_W'(k)) scan_prate = prate_a[k];
    for (int e = 0; e < NUM_PRESETS; e++)
      if (idx_q == IDX_W'(e)) begin
        ent_par = ppar_a[e];
        ent_tgt = ptgt_a[e];
      end
    for (int k = 0; k < NUM_PARENTS; k++)
      if (ent_par == PIDX_W'(k)) ent_prate = prate_a[k];
  end

  assign scan_end  = (idx_q == IDX_W'(NUM_PARENTS));
  assign pre_end   = (idx_q == IDX_W'(NUM_PRESETS));
  assign div_int   = decode_div(DIV_MODE, DIV_W, int'(code_q));
  // quotient is zero once the shift passes the rate width
  assign over      = (DIV_MODE == DM_POW2) && (int'(code_q) >= RATE_W);
  assign par_ok    = int'(ent_par) < NUM_PARENTS;
  assign last_code = (int'(code_q) == CODES - 1);

  logic              div_start, div_done;
  logic [RATE_W-1:0] div_num, div_den, div_quo, div_rem;

  assign div_start = (st_q == S_NEXT) &&
                     (preset_q ? (!pre_end && (ent_tgt != '0) && par_ok)
                               : (!scan_end && !over && (div_int != 0)));
  assign div_num   = preset_q ? ent_prate : scan_prate;
  assign div_den   = preset_q ? ent_tgt : RATE_W'(div_int);

  rs_divider #(.W(RATE_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .quo_o   (div_quo),
    .rem_o   (div_rem)
  );

  logic              off_vld, best_have, best_exact;
  logic [RATE_W-1:0] off_rate, off_prate, best_rate, best_prate;
  logic [PIDX_W-1:0] off_par, best_par;
  logic              over_off;

  assign over_off  = (st_q == S_NEXT) && !preset_q && !scan_end && over;
  assign off_vld   = over_off ||
                     ((st_q == S_DIV) && div_done && (!preset_q || (div_rem == '0)));
  assign off_rate  = over_off ? '0 : (preset_q ? tgt_q : div_quo);
  assign off_par   = over_off ? idx_q[PIDX_W-1:0] : cand_par_q;
  assign off_prate = over_off ? scan_prate : cand_prate_q;

  rs_best #(.RATE_W(RATE_W), .PIDX_W(PIDX_W)) i_best (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   ((st_q == S_IDLE) && start_i),
    .vld_i   (off_vld),
    .rate_i  (off_rate),
    .par_i   (off_par),
    .prate_i (off_prate),
    .req_i   (req_q),
    .have_o  (best_have),
    .exact_o (best_exact),
    .rate_o  (best_rate),
    .par_o   (best_par),
    .prate_o (best_prate)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      preset_q     <= 1'b0;
      req_q        <= '0;
      tgt_q        <= '0;
      cand_prate_q <= '0;
      cand_par_q   <= '0;
      idx_q        <= '0;
      code_q       <= '0;
      done_q       <= 1'b0;
      err_q        <= 1'b0;
      par_q        <= '0;
      prate_q      <= '0;
      rate_q       <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          preset_q <= preset_en_i;
          req_q    <= req_rate_i;
          idx_q    <= '0;
          code_q   <= '0;
          st_q     <= S_NEXT;
        end
        S_NEXT: if (preset_q) begin
          if (pre_end) st_q <= S_FIN;
          else if (div_start) begin
            tgt_q        <= ent_tgt;
            cand_par_q   <= ent_par;
            cand_prate_q <= ent_prate;
            st_q         <= S_DIV;
          end else idx_q <= idx_q + IDX_W'(1);
        end else begin
          if (scan_end) st_q <= S_FIN;
          else if (over) st_q <= S_CHK;
          else if (div_start) begin
            cand_par_q   <= idx_q[PIDX_W-1:0];
            cand_prate_q <= scan_prate;
            st_q         <= S_DIV;
          end else if (last_code) begin
            code_q <= '0;
            idx_q  <= idx_q + IDX_W'(1);
          end else code_q <= code_q + CODE_W'(1);
        end
        S_DIV: if (div_done) st_q <= S_CHK;
        S_CHK: begin
          if (best_exact) st_q <= S_FIN;
          else begin
            st_q <= S_NEXT;
            if (preset_q || last_code) begin
              code_q <= '0;
              idx_q  <= idx_q + IDX_W'(1);
            end else code_q <= code_q + CODE_W'(1);
          end
        end
        S_FIN: begin
          done_q  <= 1'b1;
          err_q   <= !best_have;
          par_q   <= best_have ? best_par : '0;
          prate_q <= best_have ? best_prate : '0;
          rate_q  <= best_have ? best_rate : '0;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign err_o      = err_q;
  assign par_idx_o  = par_q;
  assign par_rate_o = prate_q;
  assign rate_o     = rate_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R4
  div_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_start |-> (div_den != '0));

  // R2
  scan_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !err_q && !preset_q) |-> (rate_q <= prate_q));

  // R7
  preset_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !err_q && preset_q) |-> ((rate_q != '0) && ((prate_q % rate_q) == '0)));
endmodule

// File: tb/test_rs_search.sv
`timescale 1ns/1ps
module test_rs_search;
  localparam int NP = 4;
  localparam int NE = 4;
  localparam int RW = 16;
  localparam int DW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              start = 1'b0;
  logic              pre_en = 1'b0;
  logic [RW-1:0]     req = '0;
  logic [NP*RW-1:0]  pr_flat;
  logic [NE*2-1:0]   pp_flat;
  logic [NE*RW-1:0]  pt_flat;
  int pr [NP];
  int pp [NE];
  int pt [NE];

  always_comb begin
    for (int i = 0; i < NP; i++) pr_flat[i*RW +: RW] = RW'(pr[i]);
    for (int i = 0; i < NE; i++) begin
      pp_flat[i*2 +: 2]   = 2'(pp[i]);
      pt_flat[i*RW +: RW] = RW'(pt[i]);
    end
  end

  logic          done_w [4];
  logic          err_w  [4];
  logic [1:0]    par_w  [4];
  logic [RW-1:0] prt_w  [4];
  logic [RW-1:0] rate_w [4];

  for (genvar g = 0; g < 4; g++) begin : g_dut
    rs_search #(.NUM_PARENTS(NP), .NUM_PRESETS(NE), .RATE_W(RW), .DIV_W(DW),
                .DIV_MODE(rs_pkg::div_mode_e'(g))) i_rs_search (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .preset_en_i(pre_en),
      .req_rate_i(req), .parent_rates_i(pr_flat), .preset_par_i(pp_flat),
      .preset_rate_i(pt_flat), .done_o(done_w[g]), .err_o(err_w[g]),
      .par_idx_o(par_w[g]), .par_rate_o(prt_w[g]), .rate_o(rate_w[g]));
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ndone [4];
  int done_cyc [4];
  int pulse_bad = 0;
  logic prev_done [4];

  initial for (int k = 0; k < 4; k++) begin ndone[k] = 0; prev_done[k] = 1'b0; done_cyc[k] = 0; end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (done_w[k]) begin
        ndone[k] = ndone[k] + 1;
        done_cyc[k] = cyc;
        if (prev_done[k]) pulse_bad = pulse_bad + 1;
      end
      prev_done[k] = done_w[k];
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int maxc(int m);
    case (m)
      1: return 7;
      2: return 128;
      3: return 8;
      default: return 8;
    endcase
  endfunction

  function automatic int dec(int m, int c);
    case (m)
      1: return c;
      2: return 1 << c;
      3: return (c < 4) ? 2 * (c + 1) : 0;
      default: return c + 1;
    endcase
  endfunction

  function automatic void ref_search(int m, bit p_en, int rq,
                                     output int e_err, output int e_par,
                                     output int e_prt, output int e_rate);
    bit have = 0;
    bit fin = 0;
    int bg = 0;
    int cand, gap, d;
    e_err = 0; e_par = 0; e_prt = 0; e_rate = 0;
    if (p_en) begin
      for (int e = 0; e < NE; e++) begin
        if (fin) break;
        if (pt[e] == 0 || pp[e] >= NP) continue;
        if (pr[pp[e]] % pt[e] != 0) continue;
        cand = pt[e];
        gap = (cand > rq) ? cand - rq : rq - cand;
        if (!have || gap < bg) begin
          have = 1; bg = gap; e_par = pp[e]; e_prt = pr[pp[e]]; e_rate = cand;
          if (gap == 0) fin = 1;
        end
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        for (int c = 0; c < maxc(m); c++) begin
          if (fin) break;
          if (m == 2 && c >= RW) cand = 0;
          else begin
            d = dec(m, c);
            if (d == 0) continue;
            cand = pr[p] / d;
          end
          gap = (cand > rq) ? cand - rq : rq - cand;
          if (!have || gap < bg) begin
            have = 1; bg = gap; e_par = p; e_prt = pr[p]; e_rate = cand;
            if (gap == 0) fin = 1;
          end
        end
      end
    end
    if (!have) begin e_err = 1; e_par = 0; e_prt = 0; e_rate = 0; end
  endfunction

  int snap [4];
  int t0;

  task automatic launch(bit p_en, int rq);
    @(negedge clk);
    for (int k = 0; k < 4; k++) snap[k] = ndone[k];
    pre_en = p_en;
    req = RW'(rq);
    start = 1'b1;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_all();
    int n = 0;
    bit all;
    forever begin
      all = 1;
      for (int k = 0; k < 4; k++) if (ndone[k] <= snap[k]) all = 0;
      if (all) break;
      n++;
      if (n > 6000) begin
        checks++; errors++;
        $display("FAIL watchdog actual %0d expected %0d", n, 6000);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic compare(string r, bit p_en, int rq);
    int e_err, e_par, e_prt, e_rate;
    for (int k = 0; k < 4; k++) begin
      ref_search(k, p_en, rq, e_err, e_par, e_prt, e_rate);
      chk(r, int'(err_w[k]) * 0 + int'(last_err[k]), e_err);
      chk(r, int'(par_w[k]), e_par);
      chk(r, int'(prt_w[k]), e_prt);
      chk(r, int'(rate_w[k]), e_rate);
    end
  endtask

  logic last_err [4];
  always @(negedge clk) for (int k = 0; k < 4; k++) if (done_w[k]) last_err[k] = err_w[k];

  task automatic run(string r, bit p_en, int rq);
    launch(p_en, rq);
    wait_all();
    compare(r, p_en, rq);
  endtask

  int seed = 7;
  function automatic int lcg();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff_ffff;
  endfunction

  initial begin
    pr = '{1000, 750, 333, 0};
    pp = '{0, 0, 0, 0};
    pt = '{0, 0, 0, 0};
    for (int k = 0; k < 4; k++) last_err[k] = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      chk("R1", int'(done_w[k]), 0);
      chk("R1", int'(err_w[k]), 0);
      chk("R1", int'(rate_w[k]), 0);
      chk("R1", int'(prt_w[k]), 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R11 sweep over modes, fixed parent set with a zero-rate parent
    foreach (pr[i]) ;
    begin
      int rqs [8] = '{0, 1, 77, 125, 333, 999, 5000, 400};
      foreach (rqs[i]) run("R2", 1'b0, rqs[i]);
    end
    // R3 R4 generated parent sets
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < NP; i++) pr[i] = (lcg() % 4000) + 1;
      for (int j = 0; j < 3; j++) run("R3", 1'b0, lcg() % 4500);
    end
    // R11 large power-of-two codes give 0: small request picks rate 0 in mode 2
    pr = '{5, 6, 7, 9};
    run("R11", 1'b0, 0);
    chk("R11", int'(rate_w[2]), 0);

    // R5 ties keep the earlier candidate
    pr = '{600, 600, 600, 600};
    run("R5", 1'b0, 450);
    chk("R5", int'(par_w[0]), 0);
    chk("R5", int'(rate_w[0]), 600);

    // R6 exact match on first candidate exits early
    pr = '{800, 100, 200, 300};
    run("R6", 1'b0, 800);
    chk("R6", int'((done_cyc[0] - t0) < 40), 1);

    // R7 preset entries, mixed valid and invalid
    pr = '{1200, 1000, 700, 64};
    pp = '{1, 3, 0, 2};
    pt = '{300, 16, 0, 350};
    run("R7", 1'b1, 20);
    chk("R7", int'(rate_w[0]), 16);
    run("R7", 1'b1, 340);
    chk("R7", int'(rate_w[1]), 350);
    chk("R7", int'(par_w[1]), 2);
    run("R7", 1'b1, 1000);

    // R8 no valid entry
    pr = '{1000, 1000, 1000, 1000};
    pp = '{0, 1, 2, 3};
    pt = '{7, 0, 3, 9};
    run("R8", 1'b1, 50);
    chk("R8", int'(last_err[3]), 1);

    // R10 second start while busy is ignored, request is captured
    pr = '{1000, 750, 333, 90};
    launch(1'b0, 260);
    repeat (3) @(negedge clk);
    req = RW'(999);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_all();
    compare("R10", 1'b0, 260);
    repeat (60) @(negedge clk);
    for (int k = 0; k < 4; k++) chk("R10", ndone[k] - snap[k], 1);

    // R9 done is a single-cycle pulse
    chk("R9", pulse_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule